// File: doc/BRIEF.md
# Converter Start Sequencer with Control and Result Registers

This block is the digital front end of an eight-input multiplexed 12-bit successive-approximation converter. Software programs one control word that selects which inputs take part, sets the divider for the converter clock, powers the converter up or down, and chooses how conversions begin. A conversion can begin in one of three ways:

- right away, on a software command;
- on a chosen edge of one of six external trigger inputs;
- in a continuous scan over every selected input.

The analog converter sits outside the block. It is reached through a plain handshake. The block raises a one-cycle start strobe together with a channel number. The converter answers with busy while it works, then gives a one-cycle done pulse with a 12-bit result. Each finished conversion goes into a data word that software reads. That word holds a done flag, the channel number and the result. Reading the word clears the flag.

Top module: `convseq_top`

## Requirements
- R1: The control word keeps its fields at fixed bit positions: input mask [7:0], clock divisor [15:8], scan enable [16], power [21], start mode [26:24] and edge polarity [27]. Every other bit reads back as 0 whatever was written to it.
- R2: A mask of all zeros behaves exactly as a mask with only bit 0 set, so conversions use channel 0.
- R3: While power is set, `cv_tick` pulses once every (divisor + 1) bus clocks, which is every cycle when the divisor is 0. While power is clear, `cv_tick` stays low.
- R4: With scan off, start mode 000 starts nothing. Mode 001 starts exactly one conversion on the lowest-numbered selected channel. The start field then reads back as 000, and no further conversion starts until the next write.
- R5: With scan off, start modes 010 to 111 choose trigger input 0 to 5 in that order. Edge bit 1 starts a conversion of the lowest selected channel on a rising edge of the chosen input, and edge bit 0 does so on a falling edge. The opposite edge starts nothing. Edges on the inputs that are not chosen start nothing. Edges that arrive while a conversion is in flight start nothing.
- R6: With scan on, the start field is ignored and is not changed. Conversions follow each other over the selected channels in ascending order, and after the highest selected channel the scan returns to the lowest one.
- R7: When scan is cleared while a conversion is in flight, that conversion still completes and its result is stored. No new conversion starts after it.
- R8: While the power bit is clear, `cv_pwr` is low and no start strobe is issued, whatever the start mode or scan setting.
- R9: The data word carries done in bit 31, the channel number in bits 26:24 and the 12-bit result in bits 15:4. All other bits read as 0.
- R10: A cycle with `dat_rd` high clears the done flag. A result that arrives in that same cycle sets the flag again and stores the new channel and result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read-back |
| dat_rd | input | 1 | Read strobe for the data word; clears done |
| dat_rdata | output | 32 | Data word: done, channel, result |
| trig_in | input | 6 | External trigger inputs (asynchronous) |
| cv_pwr | output | 1 | Converter power enable |
| cv_tick | output | 1 | Converter clock enable, bus clock / (divisor + 1) |
| cv_start | output | 1 | One-cycle conversion start strobe |
| cv_chan | output | 3 | Channel to convert, valid with `cv_start` |
| cv_busy | input | 1 | Converter is working |
| cv_done | input | 1 | One-cycle pulse: result is valid |
| cv_result | input | 12 | Conversion result |

## Verification
The collision of interest is a read of the data word in the very cycle that a new result comes back, because the flag's clear and set then land on the same edge. The bench's converter model can raise its own read strobe together with the done pulse of a chosen conversion. The test passes only when the flag is still set afterwards and the word holds the channel and result of that late conversion. A second overlap is also exercised: a trigger edge that arrives while a conversion is still busy. The check is that the start count rises by exactly one.

// File: rtl/convseq_pkg.sv
`timescale 1ns/1ps
package convseq_pkg;

   // Control word field positions (decoded by software, so fixed)
   localparam int CW_MASK_LSB  = 0;
   localparam int CW_DIV_LSB   = 8;
   localparam int CW_SCAN_BIT  = 16;
   localparam int CW_PWR_BIT   = 21;
   localparam int CW_MODE_LSB  = 24;
   localparam int CW_MODE_W    = 3;
   localparam int CW_EDGE_BIT  = 27;

   // Data word field positions
   localparam int DW_DONE_BIT  = 31;
   localparam int DW_CH_LSB    = 24;
   localparam int DW_CH_W      = 3;
   localparam int DW_RES_MSB   = 15;

   // Start modes
   localparam logic [CW_MODE_W-1:0] MODE_OFF  = 3'd0;
   localparam logic [CW_MODE_W-1:0] MODE_SOFT = 3'd1;
   localparam logic [CW_MODE_W-1:0] MODE_TRG0 = 3'd2;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_BUSY = 1'b1
   } seq_state_e;

endpackage

// File: rtl/convseq_regs.sv
`timescale 1ns/1ps
module convseq_regs
   import convseq_pkg::*;
#(
   parameter int N_CH  = 8,
   parameter int DIV_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_wr,
   input  logic [31:0]          ctl_wdata,
   input  logic                 clr_mode,
   output logic [31:0]          ctl_rdata,
   output logic [N_CH-1:0]      mask_o,
   output logic [DIV_W-1:0]     div_o,
   output logic                 scan_o,
   output logic                 pwr_o,
   output logic [CW_MODE_W-1:0] mode_o,
   output logic                 rise_o
);

   if (N_CH < 2 || N_CH > 8) begin : g_bad_nch
      $error("convseq_regs: N_CH must be 2..8");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_divw
      $error("convseq_regs: DIV_W must be 1..8");
   end

   logic [N_CH-1:0]      sel_q;
   logic [DIV_W-1:0]     div_q;
   logic                 scan_q;
   logic                 pwr_q;
   logic [CW_MODE_W-1:0] mode_q;
   logic                 edge_q;
   logic                 unused_wbits;

   assign unused_wbits = ^ctl_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         div_q  <= '0;
         scan_q <= 1'b0;
         pwr_q  <= 1'b0;
         mode_q <= MODE_OFF;
         edge_q <= 1'b0;
      end else if (ctl_wr) begin
         sel_q  <= ctl_wdata[CW_MASK_LSB +: N_CH];
         div_q  <= ctl_wdata[CW_DIV_LSB +: DIV_W];
         scan_q <= ctl_wdata[CW_SCAN_BIT];
         pwr_q  <= ctl_wdata[CW_PWR_BIT];
         mode_q <= ctl_wdata[CW_MODE_LSB +: CW_MODE_W];
         edge_q <= ctl_wdata[CW_EDGE_BIT];
      end else if (clr_mode) begin
         mode_q <= MODE_OFF;
      end
   end

   // An empty mask stands for channel 0 alone
   assign mask_o = (sel_q == '0) ? {{(N_CH-1){1'b0}}, 1'b1} : sel_q;
   assign div_o  = div_q;
   assign scan_o = scan_q;
   assign pwr_o  = pwr_q;
   assign mode_o = mode_q;
   assign rise_o = edge_q;

   always_comb begin
      ctl_rdata = '0;
      ctl_rdata[CW_MASK_LSB +: N_CH]      = sel_q;
      ctl_rdata[CW_DIV_LSB +: DIV_W]      = div_q;
      ctl_rdata[CW_SCAN_BIT]              = scan_q;
      ctl_rdata[CW_PWR_BIT]               = pwr_q;
      ctl_rdata[CW_MODE_LSB +: CW_MODE_W] = mode_q;
      ctl_rdata[CW_EDGE_BIT]              = edge_q;
   end

   AST_SOFT_FIELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mode && !ctl_wr) |=> (mode_o == MODE_OFF)); // R4

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (pwr_o == $past(ctl_wdata[CW_PWR_BIT]))); // R1

endmodule

// File: rtl/convseq_clkdiv.sv
`timescale 1ns/1ps
module convseq_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic             tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else if (cnt_q >= div) begin
         cnt_q  <= '0;
         tick_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick_q <= 1'b0;
      end
   end

   assign tick = tick_q;

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick); // R3

   AST_TICK_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !tick); // R3

endmodule

// File: rtl/convseq_trig.sv
`timescale 1ns/1ps
module convseq_trig
   import convseq_pkg::*;
#(
   parameter int N_TRIG      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_TRIG-1:0]    trig_in,
   input  logic [CW_MODE_W-1:0] mode,
   input  logic                 rise,
   output logic                 fire
);

   if (N_TRIG != 6) begin : g_bad_ntrig
      $error("convseq_trig: start modes address exactly six trigger inputs");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("convseq_trig: SYNC_STAGES must be 0..4");
   end

   logic [N_TRIG-1:0] trig_s;
   logic [N_TRIG-1:0] prev_q;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign trig_s = trig_in;
   end else begin : g_sync
      logic [N_TRIG-1:0] stage_q [SYNC_STAGES];
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else if (s == 0) begin
               stage_q[s] <= trig_in;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
      assign trig_s = stage_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= trig_s;
   end

   logic [7:0]           cur_pad;
   logic [7:0]           prv_pad;
   logic [CW_MODE_W-1:0] idx;
   logic                 armed;

   assign cur_pad = 8'(trig_s);
   assign prv_pad = 8'(prev_q);
   assign idx     = mode - MODE_TRG0;
   assign armed   = (mode >= MODE_TRG0);

   always_comb begin
      fire = 1'b0;
      if (armed) begin
         if (rise) fire = cur_pad[idx] & ~prv_pad[idx];
         else      fire = ~cur_pad[idx] & prv_pad[idx];
      end
   end

endmodule

// File: rtl/convseq_fsm.sv
`timescale 1ns/1ps
module convseq_fsm
   import convseq_pkg::*;
#(
   parameter int N_CH = 8,
   localparam int CH_W = $clog2(N_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_wr,
   input  logic                 pwr,
   input  logic                 scan,
   input  logic [CW_MODE_W-1:0] mode,
   input  logic [N_CH-1:0]      mask,
   input  logic                 fire,
   input  logic                 cv_busy,
   input  logic                 cv_done,
   output logic                 cv_start,
   output logic [CH_W-1:0]      cv_chan,
   output logic                 clr_mode,
   output logic                 cap
);

   // First selected channel strictly after 'from', wrapping
   function automatic logic [CH_W-1:0] pick_after(input logic [N_CH-1:0] m,
                                                  input logic [CH_W-1:0] from);
      logic [CH_W-1:0] r;
      logic            hit;
      int              c;
      r   = '0;
      hit = 1'b0;
      for (int k = 1; k <= N_CH; k++) begin
         c = (int'(from) + k) % N_CH;
         if (!hit && m[c]) begin
            r   = CH_W'(c);
            hit = 1'b1;
         end
      end
      return r;
   endfunction

   localparam logic [CH_W-1:0] TOP_CH = CH_W'(N_CH - 1);

   seq_state_e      state_q;
   logic [CH_W-1:0] last_q;
   logic [CH_W-1:0] chan_q;
   logic            start_q;

   logic [CH_W-1:0] scan_nxt;
   logic [CH_W-1:0] lowest;
   logic            ready;
   logic            go_soft;
   logic            go_trig;
   logic            go_scan;
   logic            go;

   always_comb begin
      scan_nxt = pick_after(mask, last_q);
      lowest   = pick_after(mask, TOP_CH);
      ready    = (state_q == SQ_IDLE) && pwr && !cv_busy;
      go_scan  = ready && scan;
      go_soft  = ready && !scan && (mode == MODE_SOFT);
      go_trig  = ready && !scan && (mode >= MODE_TRG0) && fire;
      go       = go_scan || go_soft || go_trig;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         last_q  <= TOP_CH;
         chan_q  <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= go;
         if (go) begin
            chan_q <= scan ? scan_nxt : lowest;
         end
         if (ctl_wr) begin
            last_q <= TOP_CH;
         end else if (go_scan) begin
            last_q <= scan_nxt;
         end
         if (go) begin
            state_q <= SQ_BUSY;
         end else if (state_q == SQ_BUSY && cv_done) begin
            state_q <= SQ_IDLE;
         end
      end
   end

   assign cv_start = start_q;
   assign cv_chan  = chan_q;
   assign clr_mode = go_soft;
   assign cap      = (state_q == SQ_BUSY) && cv_done;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |=> !cv_start); // R4

   AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |-> $past(pwr)); // R8

   AST_START_NOT_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |-> ($past(scan) || $past(mode) != MODE_OFF)); // R4

   AST_CHAN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |-> (|($past(mask) & ((N_CH)'(1) << cv_chan)))); // R2

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |-> !$past(cv_busy)); // R5

endmodule

// File: rtl/convseq_result.sv
`timescale 1ns/1ps
module convseq_result
   import convseq_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [CH_W-1:0]  cap_ch,
   input  logic [RES_W-1:0] cap_res,
   input  logic             rd,
   output logic [31:0]      dat_rdata
);

   if (RES_W < 1 || RES_W > 12) begin : g_bad_resw
      $error("convseq_result: RES_W must be 1..12");
   end
   if (CH_W > DW_CH_W) begin : g_bad_chw
      $error("convseq_result: channel field is three bits");
   end

   logic                done_q;
   logic [DW_CH_W-1:0]  ch_q;
   logic [RES_W-1:0]    res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ch_q   <= '0;
         res_q  <= '0;
      end else begin
         if (cap) begin
            done_q <= 1'b1;
            ch_q   <= DW_CH_W'(cap_ch);
            res_q  <= cap_res;
         end else if (rd) begin
            done_q <= 1'b0;
         end
      end
   end

   always_comb begin
      dat_rdata = '0;
      dat_rdata[DW_DONE_BIT]               = done_q;
      dat_rdata[DW_CH_LSB +: DW_CH_W]      = ch_q;
      dat_rdata[DW_RES_MSB -: RES_W]       = res_q;
   end

   AST_DONE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> dat_rdata[DW_DONE_BIT]); // R10

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !cap) |=> !dat_rdata[DW_DONE_BIT]); // R10

   AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(dat_rdata[30:0])); // R9

endmodule

// File: rtl/convseq_top.sv
`timescale 1ns/1ps
module convseq_top
   import convseq_pkg::*;
#(
   parameter int N_CH        = 8,
   parameter int DIV_W       = 8,
   parameter int RES_W       = 12,
   parameter int N_TRIG      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ctl_wr,
   input  logic [31:0]               ctl_wdata,
   output logic [31:0]               ctl_rdata,
   input  logic                      dat_rd,
   output logic [31:0]               dat_rdata,
   input  logic [N_TRIG-1:0]         trig_in,
   output logic                      cv_pwr,
   output logic                      cv_tick,
   output logic                      cv_start,
   output logic [$clog2(N_CH)-1:0]   cv_chan,
   input  logic                      cv_busy,
   input  logic                      cv_done,
   input  logic [RES_W-1:0]          cv_result
);

   localparam int CH_W = $clog2(N_CH);

   logic [N_CH-1:0]      mask;
   logic [DIV_W-1:0]     div;
   logic                 scan;
   logic                 pwr;
   logic [CW_MODE_W-1:0] mode;
   logic                 rise;
   logic                 clr_mode;
   logic                 fire;
   logic                 cap;

   convseq_regs #(.N_CH(N_CH), .DIV_W(DIV_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .clr_mode  (clr_mode),
      .ctl_rdata (ctl_rdata),
      .mask_o    (mask),
      .div_o     (div),
      .scan_o    (scan),
      .pwr_o     (pwr),
      .mode_o    (mode),
      .rise_o    (rise)
   );

   convseq_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pwr),
      .div   (div),
      .tick  (cv_tick)
   );

   convseq_trig #(.N_TRIG(N_TRIG), .SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_in (trig_in),
      .mode    (mode),
      .rise    (rise),
      .fire    (fire)
   );

   convseq_fsm #(.N_CH(N_CH)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .pwr      (pwr),
      .scan     (scan),
      .mode     (mode),
      .mask     (mask),
      .fire     (fire),
      .cv_busy  (cv_busy),
      .cv_done  (cv_done),
      .cv_start (cv_start),
      .cv_chan  (cv_chan),
      .clr_mode (clr_mode),
      .cap      (cap)
   );

   convseq_result #(.RES_W(RES_W), .CH_W(CH_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap),
      .cap_ch    (cv_chan),
      .cap_res   (cv_result),
      .rd        (dat_rd),
      .dat_rdata (dat_rdata)
   );

   assign cv_pwr = pwr;

   AST_UNPOWERED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cv_pwr |=> !cv_start); // R8

endmodule

// File: tb/convseq_top_tb_top.sv
`timescale 1ns/1ps
module convseq_top_tb_top;

   localparam int LAT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr;
   logic [31:0] ctl_wdata;
   logic [31:0] ctl_rdata;
   logic        dat_rd;
   logic [31:0] dat_rdata;
   logic [5:0]  trig;
   logic        cv_pwr, cv_tick, cv_start;
   logic [2:0]  cv_chan;
   logic        cv_busy, cv_done;
   logic [11:0] cv_result;

   logic main_rd = 1'b0;
   logic mdl_rd  = 1'b0;
   bit   rd_on_done = 1'b0;
   assign dat_rd = main_rd | mdl_rd;

   int n_chk = 0, n_fail = 0, starts = 0, results = 0;
   int exp_q[$];

   always #10 clk = ~clk;

   convseq_top dut_i (
      .clk (clk), .rst_n (rst_n),
      .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata), .ctl_rdata (ctl_rdata),
      .dat_rd (dat_rd), .dat_rdata (dat_rdata),
      .trig_in (trig),
      .cv_pwr (cv_pwr), .cv_tick (cv_tick), .cv_start (cv_start), .cv_chan (cv_chan),
      .cv_busy (cv_busy), .cv_done (cv_done), .cv_result (cv_result)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] res_of(input int ch, input int idx);
      return 12'((ch * 37 + idx * 5 + 11) % 4096);
   endfunction

   task automatic wr_ctl(input logic [31:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick_gap(output int g);
      int w;
      w = 0; g = 0;
      do begin @(negedge clk); w++; end while (!cv_tick && w < 100);
      do begin @(negedge clk); g++; end while (!cv_tick && g < 100);
   endtask

   task automatic count_ticks(input int n, output int t);
      t = 0;
      repeat (n) begin @(negedge clk); if (cv_tick) t++; end
   endtask

   // Converter model: reacts to a start, busy for LAT cycles, then done
   initial begin
      cv_busy = 1'b0; cv_done = 1'b0; cv_result = '0;
      forever begin
         @(negedge clk);
         if (rst_n && cv_start) begin
            int ch, id;
            ch = int'(cv_chan);
            id = starts;
            starts++;
            cv_busy = 1'b1;
            repeat (LAT - 1) @(negedge clk);
            cv_result = res_of(ch, id);
            cv_done = 1'b1; cv_busy = 1'b0; mdl_rd = rd_on_done;
            @(negedge clk);
            cv_done = 1'b0; mdl_rd = 1'b0;
         end
      end
   end

   // Scoreboard monitor: one expected channel per finished conversion
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n && cv_done) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 result with no expected entry", dat_rdata, 32'h0);
            end else begin
               int ch;
               ch = exp_q.pop_front();
               chk(dat_rdata[31] == 1'b1, "R10 done set by new result", dat_rdata, 32'h8000_0000);
               chk(dat_rdata[26:24] == 3'(ch), "R9 channel field", 32'(dat_rdata[26:24]), 32'(ch));
               chk(dat_rdata[15:4] == res_of(ch, results), "R9 result field",
                   32'(dat_rdata[15:4]), 32'(res_of(ch, results)));
               chk((dat_rdata & ~32'h8700_FFF0) == 0, "R9 reserved bits zero", dat_rdata, 32'h0);
               results++;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int s0, r0, g, t, w;
      logic [31:0] snap;
      ctl_wr = 1'b0; ctl_wdata = '0; trig = '0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      chk(ctl_rdata == 32'h0, "R1 reset control word", ctl_rdata, 32'h0);
      chk(dat_rdata == 32'h0, "R9 reset data word", dat_rdata, 32'h0);
      chk(cv_pwr == 1'b0, "R8 reset powered down", 32'(cv_pwr), 32'h0);
      chk(cv_start == 1'b0, "R4 reset no start", 32'(cv_start), 32'h0);

      // R1 reserved bits, R8 scan set but unpowered
      s0 = starts;
      wr_ctl(32'hFFDF_FFFF);
      count_ticks(30, t);
      chk(ctl_rdata == 32'h0F01_FFFF, "R1 field readback", ctl_rdata, 32'h0F01_FFFF);
      chk(cv_pwr == 1'b0, "R8 power pin low", 32'(cv_pwr), 32'h0);
      chk(starts == s0, "R8 no start while unpowered", 32'(starts - s0), 32'h0);
      chk(t == 0, "R3 no tick while unpowered", 32'(t), 32'h0);

      // R3 clock divider
      wr_ctl(32'h0020_0300);
      tick_gap(g);
      chk(g == 4, "R3 divisor 3 gives period 4", 32'(g), 32'd4);
      wr_ctl(32'h0020_0000);
      tick_gap(g);
      chk(g == 1, "R3 divisor 0 gives every cycle", 32'(g), 32'd1);
      wr_ctl(32'h0000_0300);
      count_ticks(20, t);
      chk(t == 0, "R3 ticks stop when power cleared", 32'(t), 32'h0);

      // R4 mode 000 starts nothing
      s0 = starts;
      wr_ctl(32'h0020_0014);
      wait_cyc(20);
      chk(starts == s0, "R4 idle mode no start", 32'(starts - s0), 32'h0);

      // R4 software start on lowest selected (ch2 of {2,4})
      exp_q.push_back(2);
      wr_ctl(32'h0120_0014);
      wait_cyc(30);
      chk(starts == s0 + 1, "R4 single software start", 32'(starts - s0), 32'd1);
      chk(ctl_rdata == 32'h0020_0014, "R4 start field back to 000", ctl_rdata, 32'h0020_0014);
      wait_cyc(20);
      chk(starts == s0 + 1, "R4 no repeat without write", 32'(starts - s0), 32'd1);
      snap = {1'b1, 4'b0, 3'd2, 8'b0, res_of(2, results - 1), 4'b0};
      chk(dat_rdata == snap, "R9 full data word", dat_rdata, snap);

      // R10 read clears done only
      main_rd = 1'b0;
      @(negedge clk); main_rd = 1'b1;
      @(negedge clk); main_rd = 1'b0;
      chk(dat_rdata == (snap & 32'h7FFF_FFFF), "R10 read clears done", dat_rdata,
          snap & 32'h7FFF_FFFF);

      // R2 empty mask means channel 0
      s0 = starts;
      exp_q.push_back(0);
      wr_ctl(32'h0120_0000);
      wait_cyc(30);
      chk(starts == s0 + 1, "R2 empty mask converts", 32'(starts - s0), 32'd1);

      // R10 read in the same cycle as a new result
      rd_on_done = 1'b1;
      exp_q.push_back(5);
      wr_ctl(32'h0120_0020);
      wait_cyc(30);
      rd_on_done = 1'b0;
      chk(dat_rdata[31] == 1'b1, "R10 new result wins over read", dat_rdata, 32'h8000_0000);
      chk(dat_rdata[26:24] == 3'd5, "R10 collided result channel", 32'(dat_rdata[26:24]), 32'd5);

      // R5 external triggers: mode 011 -> input 1, edge rising, ch3
      s0 = starts;
      wr_ctl(32'h0B20_0008);
      wait_cyc(5);
      trig[0] = 1'b1;
      wait_cyc(20);
      chk(starts == s0, "R5 unchosen input ignored", 32'(starts - s0), 32'h0);
      exp_q.push_back(3);
      trig[1] = 1'b1;
      wait_cyc(25);
      chk(starts == s0 + 1, "R5 rising edge starts", 32'(starts - s0), 32'd1);
      trig[1] = 1'b0;
      wait_cyc(20);
      chk(starts == s0 + 1, "R5 falling ignored with edge 1", 32'(starts - s0), 32'd1);
      wr_ctl(32'h0320_0008);
      trig[1] = 1'b1;
      wait_cyc(20);
      chk(starts == s0 + 1, "R5 rising ignored with edge 0", 32'(starts - s0), 32'd1);
      exp_q.push_back(3);
      trig[1] = 1'b0;
      wait_cyc(25);
      chk(starts == s0 + 2, "R5 falling edge starts", 32'(starts - s0), 32'd2);
      // edge arriving during a conversion
      wr_ctl(32'h0B20_0008);
      exp_q.push_back(3);
      trig[1] = 1'b1;
      w = 0;
      do begin @(posedge clk); w++; end while (!cv_busy && w < 50);
      @(negedge clk); trig[1] = 1'b0;
      wait_cyc(2);   trig[1] = 1'b1;
      wait_cyc(30);
      chk(starts == s0 + 3, "R5 edge during conversion ignored", 32'(starts - s0), 32'd3);
      wr_ctl(32'h0020_0008);
      trig = '0;
      wait_cyc(10);

      // R6 scan over {2,5,7} with start field 001; R7 stop mid-conversion
      s0 = starts; r0 = results;
      for (int i = 0; i < 12; i++) exp_q.push_back((i % 3 == 0) ? 2 : (i % 3 == 1) ? 5 : 7);
      wr_ctl(32'h0121_00A4);
      w = 0;
      do begin @(posedge clk); w++; end while (starts < s0 + 5 && w < 500);
      @(negedge clk);
      chk(ctl_rdata[26:24] == 3'd1, "R6 start field untouched in scan",
          32'(ctl_rdata[26:24]), 32'd1);
      chk(cv_busy == 1'b1, "R7 stop issued during conversion", 32'(cv_busy), 32'd1);
      wr_ctl(32'h0020_00A4);
      wait_cyc(40);
      chk(starts == s0 + 5, "R7 no start after scan cleared", 32'(starts - s0), 32'd5);
      chk(results == r0 + 5, "R7 in-flight result stored", 32'(results - r0), 32'd5);
      chk(exp_q.size() == 7, "R6 ascending scan consumed", 32'(exp_q.size()), 32'd7);
      exp_q.delete();

      // R8 software start while unpowered
      s0 = starts;
      wr_ctl(32'h0100_0001);
      wait_cyc(30);
      chk(starts == s0, "R8 software start blocked unpowered", 32'(starts - s0), 32'h0);
      chk(cv_pwr == 1'b0, "R8 power pin low", 32'(cv_pwr), 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule